// File: doc/BRIEF.md
# SD Command Issue with Auto-Stop

This block sits between a register port and a card-side responder in an SD host. Software writes a command word, an argument word and a byte count. Writing the command word with its start bit set launches one command over a request/response handshake. The block checks that the returned length matches the response type the command asked for. It stores the returned bytes in four 32-bit response words and pulses one of two outcome flags toward the interrupt logic.

A transfer counter is loaded from the byte count. The data path decrements it by the number of bytes it moves. Once the counter is empty, a command with the auto-stop bit set makes the block issue a stop command of its own (index 12, argument 0). The programmed command and argument are left intact afterwards. A clock-change command completes without any request to the card.

Top module: `sd_cmd_issue`

## Requirements
- R1: A command write with bit 31 set starts a command, and the command word is stored as written. While that command, or an automatic stop that follows it, is in flight, `cmd_reg_o` bit 31 reads 1. It reads 0 from the cycle after the last response.
- R2: In flight, `req_valid_o` stays high with a stable `req_index_o` (command bits 5..0) and `req_arg_o` (argument word). The request ends in the cycle in which `rsp_valid_i` is high.
- R3: A start write with bit 21 (clock change) set makes no request. `cmd_done_o` pulses in the cycle after the write.
- R4: With bit 6 set (response wanted) and bit 7 clear, the responder must return a length of 4. Response bytes 0..3 (byte k at `rsp_data_i[127-8k -: 8]`) then form word 0, MSB first, and words 1 to 3 become 0.
- R5: With bits 6 and 7 set, the responder must return a length of 16. Word 0 then gets bytes 12..15, word 1 bytes 8..11, word 2 bytes 4..7 and word 3 bytes 0..3.
- R6: A responder error, or a length that differs from the one R4/R5 require, pulses `no_rsp_o` instead of `cmd_done_o`, and the response words are not changed. With bit 6 clear, any length that is not an error gives `cmd_done_o`, and the response words are not changed.
- R7: The block issues a stop command (index 12, argument 0) when bit 12 of the command word is set and the transfer counter is zero. This happens either when a command or clock-change start ends, or when a data move in idle leaves the counter at zero. Its response is judged as in R4 to R6, and `auto_done_o` pulses together with the outcome flag. The command and argument words are not changed.
- R8: A byte-count write (select 2) loads the counter; it takes priority over a move in the same cycle. A move subtracts `mv_bytes_i` and stops at zero. `data_done_o` pulses in the cycle after any move that leaves the counter at zero.
- R9: Command writes (select 0) and argument writes (select 1) are ignored while a command is in flight.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 command, 1 argument, 2 byte count |
| reg_wr_data | input | 32 | Write data |
| mv_valid_i | input | 1 | Data path moved bytes this cycle |
| mv_bytes_i | input | MV_W (11) | Bytes moved |
| cmd_reg_o | output | 32 | Command word, bit 31 = busy |
| arg_reg_o | output | 32 | Argument word |
| resp_w0_o | output | 32 | Response word 0 |
| resp_w1_o | output | 32 | Response word 1 |
| resp_w2_o | output | 32 | Response word 2 |
| resp_w3_o | output | 32 | Response word 3 |
| xfer_cnt_o | output | CNT_W (32) | Remaining transfer bytes |
| req_valid_o | output | 1 | Request to responder |
| req_index_o | output | 6 | Command index of the request |
| req_arg_o | output | 32 | Argument of the request |
| rsp_valid_i | input | 1 | Responder answers this cycle |
| rsp_err_i | input | 1 | Responder error |
| rsp_len_i | input | 5 | Response length in bytes |
| rsp_data_i | input | 128 | Response bytes, byte 0 in the top bits |
| cmd_done_o | output | 1 | Command-complete pulse |
| no_rsp_o | output | 1 | No-response pulse |
| data_done_o | output | 1 | Counter-empty pulse |
| auto_done_o | output | 1 | Automatic stop finished pulse |

## Verification
The response of a data command with auto-stop enabled can arrive in the same cycle as the data move that empties the counter. The bench provokes this by raising `rsp_valid_i` and `mv_valid_i` on the same clock. It expects the stop request in the next cycle, with the data-done and command-complete pulses together. A second collision drives a byte-count write and a move on one edge; the load must win and no data-done pulse may appear. A behavioural model in the bench predicts every output on each clock, and the outputs are compared against it.

// File: rtl/sdc_pkg.sv
// Shared definitions for the SD command issue block: command word bit
// positions, register select codes and the sequencer state type.
package sdc_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned IDX_W       = 6;
    localparam int unsigned LEN_W       = 5;
    localparam int unsigned N_RSP_WORDS = 4;

    localparam int unsigned B_START     = 31;
    localparam int unsigned B_CLKCHG    = 21;
    localparam int unsigned B_AUTOSTOP  = 12;
    localparam int unsigned B_RSP_LONG  = 7;
    localparam int unsigned B_RSP_EN    = 6;

    localparam logic [IDX_W-1:0] STOP_INDEX = IDX_W'(12);
    localparam logic [LEN_W-1:0] SHORT_LEN  = LEN_W'(4);
    localparam logic [LEN_W-1:0] LONG_LEN   = LEN_W'(16);

    localparam logic [1:0] SEL_CMD   = 2'd0;
    localparam logic [1:0] SEL_ARG   = 2'd1;
    localparam logic [1:0] SEL_BYTES = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAIN = 2'd1,
        ST_STOP = 2'd2
    } sdc_state_t;
endpackage

// File: rtl/sdc_xfer_counter.sv
// Transfer byte counter. A load takes priority over a move; a move
// subtracts and saturates at zero. Assumes MV_W <= CNT_W.
module sdc_xfer_counter #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned MV_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             move_en,
    input  logic [MV_W-1:0]  move_bytes,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             empty_pulse
);
    logic [CNT_W-1:0] move_ext;

    // Next counter value from load, saturating move, or hold.
    always_comb begin
        move_ext = CNT_W'(move_bytes);
        if (load_en)
            cnt_next = load_val;
        else if (move_en)
            cnt_next = (cnt_q > move_ext) ? (cnt_q - move_ext) : '0;
        else
            cnt_next = cnt_q;
    end

    // Counter register and the empty pulse after a move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            empty_pulse <= 1'b0;
        end else begin
            cnt_q       <= cnt_next;
            empty_pulse <= !load_en && move_en && (cnt_next == '0);
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (move_en && !load_en && (cnt_q <= move_ext)) |=> (cnt_q == '0)); // R8
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !empty_pulse); // R8
endmodule

// File: rtl/sdc_resp_capture.sv
// Response word store. On capture, a long response fills all words with
// the last four bytes landing in word 0; a short one fills word 0 from
// the first four bytes and clears the rest. Byte 0 sits in the top bits.
module sdc_resp_capture #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           capture,
    input  logic                           long_sel,
    input  logic [N_WORDS*WORD_W-1:0]      rsp_data,
    output logic [N_WORDS-1:0][WORD_W-1:0] words_o
);
    localparam int unsigned DATA_W = N_WORDS * WORD_W;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        // Per-word store: long takes slice w, short fills word 0 only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_o[w] <= '0;
            else if (capture) begin
                if (long_sel)
                    words_o[w] <= rsp_data[w*WORD_W +: WORD_W];
                else if (w == 0)
                    words_o[w] <= rsp_data[DATA_W-1 -: WORD_W];
                else
                    words_o[w] <= '0;
            end
        end
    end

    AST_SHORT_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !long_sel) |=> (words_o[N_WORDS-1:1] == '0)); // R4
    AST_WORDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(words_o)); // R6
endmodule

// File: rtl/sdc_issue_fsm.sv
// Command sequencer. Holds the command and argument words, runs the
// request handshake, judges the response length, and inserts a stop
// command when auto-stop is enabled and the counter is empty. Assumes
// the responder answers only while a request is raised.
module sdc_issue_fsm
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              move_only,
    input  logic              cnt_zero,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [LEN_W-1:0]  rsp_len,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] arg_q,
    output logic              req_valid,
    output logic [IDX_W-1:0]  req_index,
    output logic [WORD_W-1:0] req_arg,
    output logic              cap_en,
    output logic              cap_long,
    output logic              cmd_done,
    output logic              no_rsp,
    output logic              auto_done
);
    sdc_state_t state;
    logic wr_cmd, wr_arg, start_wr, clk_start, finish, rsp_ok, stop_due;

    // Decode writes, the response verdict and the stop condition.
    always_comb begin
        wr_cmd    = wr_en && (wr_sel == SEL_CMD) && (state == ST_IDLE);
        wr_arg    = wr_en && (wr_sel == SEL_ARG) && (state == ST_IDLE);
        start_wr  = wr_cmd && wr_data[B_START];
        clk_start = start_wr && wr_data[B_CLKCHG];
        finish    = (state != ST_IDLE) && rsp_valid;
        rsp_ok    = !rsp_err && (!cmd_q[B_RSP_EN] ||
                    (cmd_q[B_RSP_LONG] ? (rsp_len == LONG_LEN)
                                       : (rsp_len == SHORT_LEN)));
        stop_due  = cmd_q[B_AUTOSTOP] && cnt_zero;
        cap_en    = finish && rsp_ok && cmd_q[B_RSP_EN];
        cap_long  = cmd_q[B_RSP_LONG];
        req_valid = (state != ST_IDLE);
        req_index = (state == ST_STOP) ? STOP_INDEX : cmd_q[IDX_W-1:0];
        req_arg   = (state == ST_STOP) ? '0 : arg_q;
    end

    // Sequencer state, stored words and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cmd_q     <= '0;
            arg_q     <= '0;
            cmd_done  <= 1'b0;
            no_rsp    <= 1'b0;
            auto_done <= 1'b0;
        end else begin
            cmd_done  <= (finish && rsp_ok) || clk_start;
            no_rsp    <= finish && !rsp_ok;
            auto_done <= finish && (state == ST_STOP);
            if (wr_arg)
                arg_q <= wr_data;
            unique case (state)
                ST_IDLE: begin
                    if (wr_cmd) begin
                        cmd_q <= wr_data;
                        if (clk_start) begin
                            if (wr_data[B_AUTOSTOP] && cnt_zero)
                                state <= ST_STOP;
                            else
                                cmd_q[B_START] <= 1'b0;
                        end else if (start_wr) begin
                            state <= ST_MAIN;
                        end
                    end else if (move_only && stop_due) begin
                        cmd_q[B_START] <= 1'b1;
                        state          <= ST_STOP;
                    end
                end
                ST_MAIN: begin
                    if (rsp_valid) begin
                        if (stop_due)
                            state <= ST_STOP;
                        else begin
                            state          <= ST_IDLE;
                            cmd_q[B_START] <= 1'b0;
                        end
                    end
                end
                ST_STOP: begin
                    if (rsp_valid) begin
                        state          <= ST_IDLE;
                        cmd_q[B_START] <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=>
        (req_valid && $stable(req_index) && $stable(req_arg))); // R2
    AST_BUSY_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> cmd_q[B_START]); // R1
    AST_CLKCHG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_CMD) && (state == ST_IDLE) &&
         wr_data[B_START] && wr_data[B_CLKCHG]) |=>
        (cmd_done && (state != ST_MAIN))); // R3
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && no_rsp)); // R6
    AST_STOP_HAS_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        auto_done |-> (cmd_done || no_rsp)); // R7
    AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MAIN) && !rsp_valid && wr_en && (wr_sel == SEL_CMD))
        |=> $stable(cmd_q)); // R9
    AST_ARG_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && wr_en && (wr_sel == SEL_ARG))
        |=> $stable(arg_q)); // R9
endmodule

// File: rtl/sd_cmd_issue.sv
// SD command issue with auto-stop: top level. Ties the sequencer, the
// transfer counter and the response store together. Assumes CNT_W is
// at most 32 and MV_W at most CNT_W.
module sd_cmd_issue
    import sdc_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned MV_W  = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr_en,
    input  logic [1:0]                    reg_wr_sel,
    input  logic [WORD_W-1:0]             reg_wr_data,
    input  logic                          mv_valid_i,
    input  logic [MV_W-1:0]               mv_bytes_i,
    output logic [WORD_W-1:0]             cmd_reg_o,
    output logic [WORD_W-1:0]             arg_reg_o,
    output logic [WORD_W-1:0]             resp_w0_o,
    output logic [WORD_W-1:0]             resp_w1_o,
    output logic [WORD_W-1:0]             resp_w2_o,
    output logic [WORD_W-1:0]             resp_w3_o,
    output logic [CNT_W-1:0]              xfer_cnt_o,
    output logic                          req_valid_o,
    output logic [IDX_W-1:0]              req_index_o,
    output logic [WORD_W-1:0]             req_arg_o,
    input  logic                          rsp_valid_i,
    input  logic                          rsp_err_i,
    input  logic [LEN_W-1:0]              rsp_len_i,
    input  logic [N_RSP_WORDS*WORD_W-1:0] rsp_data_i,
    output logic                          cmd_done_o,
    output logic                          no_rsp_o,
    output logic                          data_done_o,
    output logic                          auto_done_o
);
    logic                                bytes_wr;
    logic [CNT_W-1:0]                    cnt_next;
    logic                                cap_en, cap_long;
    logic [N_RSP_WORDS-1:0][WORD_W-1:0]  words;

    // Byte-count write strobe, shared by counter and sequencer.
    always_comb bytes_wr = reg_wr_en && (reg_wr_sel == SEL_BYTES);

    sdc_xfer_counter #(.CNT_W(CNT_W), .MV_W(MV_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (bytes_wr),
        .load_val   (reg_wr_data[CNT_W-1:0]),
        .move_en    (mv_valid_i),
        .move_bytes (mv_bytes_i),
        .cnt_q      (xfer_cnt_o),
        .cnt_next   (cnt_next),
        .empty_pulse(data_done_o)
    );

    sdc_issue_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .move_only (mv_valid_i && !bytes_wr),
        .cnt_zero  (cnt_next == '0),
        .rsp_valid (rsp_valid_i),
        .rsp_err   (rsp_err_i),
        .rsp_len   (rsp_len_i),
        .cmd_q     (cmd_reg_o),
        .arg_q     (arg_reg_o),
        .req_valid (req_valid_o),
        .req_index (req_index_o),
        .req_arg   (req_arg_o),
        .cap_en    (cap_en),
        .cap_long  (cap_long),
        .cmd_done  (cmd_done_o),
        .no_rsp    (no_rsp_o),
        .auto_done (auto_done_o)
    );

    sdc_resp_capture #(.WORD_W(WORD_W), .N_WORDS(N_RSP_WORDS)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cap_en),
        .long_sel (cap_long),
        .rsp_data (rsp_data_i),
        .words_o  (words)
    );

    // Unpack the response words onto their ports.
    always_comb begin
        resp_w0_o = words[0];
        resp_w1_o = words[1];
        resp_w2_o = words[2];
        resp_w3_o = words[3];
    end
endmodule

// File: tb/sim_sd_cmd_issue.sv
`timescale 1ns/1ps
module sim_sd_cmd_issue;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [1:0] reg_wr_sel = 2'd0;
    logic [31:0] reg_wr_data = '0;
    logic mv_valid_i = 1'b0;
    logic [10:0] mv_bytes_i = '0;
    logic rsp_valid_i = 1'b0, rsp_err_i = 1'b0;
    logic [4:0] rsp_len_i = '0;
    logic [127:0] rsp_data_i = '0;
    logic [31:0] cmd_reg_o, arg_reg_o, resp_w0_o, resp_w1_o, resp_w2_o, resp_w3_o;
    logic [31:0] xfer_cnt_o, req_arg_o;
    logic req_valid_o, cmd_done_o, no_rsp_o, data_done_o, auto_done_o;
    logic [5:0] req_index_o;

    always #2.5 clk = ~clk;

    sd_cmd_issue u0 (.*);

    int checks = 0, failures = 0;
    bit done_flag = 0;

    // Behavioural model state.
    int m_st = 0;
    logic [31:0] m_cmd = 0, m_arg = 0, m_cnt = 0;
    logic [31:0] m_resp [4] = '{0, 0, 0, 0};
    bit m_cd = 0, m_nr = 0, m_dd = 0, m_ad = 0;

    task automatic judge();
        bit ok;
        ok = !rsp_err_i && (!m_cmd[6] || (m_cmd[7] ? rsp_len_i == 16 : rsp_len_i == 4));
        if (ok) m_cd = 1; else m_nr = 1;
        if (ok && m_cmd[6]) begin
            if (m_cmd[7]) begin
                for (int k = 0; k < 4; k++) m_resp[k] = rsp_data_i[32*k +: 32];
            end else begin
                m_resp[0] = rsp_data_i[127:96];
                for (int k = 1; k < 4; k++) m_resp[k] = 0;
            end
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cmd = 0; m_arg = 0; m_cnt = 0;
            for (int k = 0; k < 4; k++) m_resp[k] = 0;
            m_cd = 0; m_nr = 0; m_dd = 0; m_ad = 0;
        end else begin
            bit ldw, wcmd, warg;
            logic [31:0] nc;
            ldw = reg_wr_en && reg_wr_sel == 2;
            wcmd = reg_wr_en && reg_wr_sel == 0 && m_st == 0;
            warg = reg_wr_en && reg_wr_sel == 1 && m_st == 0;
            nc = m_cnt;
            if (ldw) nc = reg_wr_data;
            else if (mv_valid_i) nc = (m_cnt > 32'(mv_bytes_i)) ? m_cnt - 32'(mv_bytes_i) : 0;
            m_dd = !ldw && mv_valid_i && nc == 0;
            m_cd = 0; m_nr = 0; m_ad = 0;
            if (m_st == 0) begin
                if (wcmd) begin
                    m_cmd = reg_wr_data;
                    if (reg_wr_data[31]) begin
                        if (reg_wr_data[21]) begin
                            m_cd = 1;
                            if (reg_wr_data[12] && nc == 0) m_st = 2;
                            else m_cmd[31] = 0;
                        end else m_st = 1;
                    end
                end else if (mv_valid_i && !ldw && m_cmd[12] && nc == 0) begin
                    m_st = 2; m_cmd[31] = 1;
                end
                if (warg) m_arg = reg_wr_data;
            end else if (rsp_valid_i) begin
                judge();
                if (m_st == 2) m_ad = 1;
                if (m_st == 1 && m_cmd[12] && nc == 0) m_st = 2;
                else begin m_st = 0; m_cmd[31] = 0; end
            end
            m_cnt = nc;
        end
    end

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1 command word", cmd_reg_o, m_cmd);
        chk("R9 argument word", arg_reg_o, m_arg);
        chk("R2 req_valid", req_valid_o, m_st != 0);
        chk("R2 R7 req_index", req_index_o, m_st == 2 ? 6'd12 : m_cmd[5:0]);
        chk("R2 R7 req_arg", req_arg_o, m_st == 2 ? 32'd0 : m_arg);
        chk("R4 resp word0", resp_w0_o, m_resp[0]);
        chk("R5 resp word1", resp_w1_o, m_resp[1]);
        chk("R5 resp word2", resp_w2_o, m_resp[2]);
        chk("R5 resp word3", resp_w3_o, m_resp[3]);
        chk("R3 cmd_done", cmd_done_o, m_cd);
        chk("R6 no_rsp", no_rsp_o, m_nr);
        chk("R7 auto_done", auto_done_o, m_ad);
        chk("R8 counter", xfer_cnt_o, m_cnt);
        chk("R8 data_done", data_done_o, m_dd);
    endtask

    task automatic tick();
        @(posedge clk); #1;
        if (rst_n) compare();
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
        tick();
        reg_wr_en = 0;
    endtask

    task automatic mv(int n);
        mv_valid_i = 1; mv_bytes_i = 11'(n);
        tick();
        mv_valid_i = 0;
    endtask

    task automatic respond(bit err, int len, logic [127:0] d, int dly);
        repeat (dly) tick();
        rsp_valid_i = 1; rsp_err_i = err; rsp_len_i = 5'(len); rsp_data_i = d;
        tick();
        rsp_valid_i = 0; rsp_err_i = 0;
    endtask

    localparam logic [31:0] LD = 32'h8000_0000, CK = 32'h0020_0000, AS = 32'h0000_1000;
    localparam logic [31:0] RL = 32'h80, RE = 32'h40, DT = 32'h200;
    localparam logic [127:0] D1 = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [127:0] D2 = 128'hDEADBEEF_01020304_0A0B0C0D_F0E0D0C0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R10: reset state at the ports.
        chk("R10 cmd reset", cmd_reg_o, 0);
        chk("R10 req reset", req_valid_o, 0);
        chk("R10 resp reset", {resp_w0_o, resp_w3_o}, 0);
        chk("R10 pulses reset", {cmd_done_o, no_rsp_o, data_done_o, auto_done_o}, 0);
        chk("R10 counter reset", xfer_cnt_o, 0);
        wr(2, 8);
        wr(1, 32'hA5A5_0001);
        wr(0, LD | RE | 17);
        respond(0, 4, D1, 2);                      // R4 short
        chk("R4 short word0", resp_w0_o, 32'h00112233);
        wr(0, LD | RE | RL | 2);
        respond(0, 16, D2, 1);                     // R5 long
        chk("R5 long word3", resp_w3_o, 32'hDEADBEEF);
        chk("R5 long word0", resp_w0_o, 32'hF0E0D0C0);
        wr(0, LD | RE | RL | 9);
        respond(0, 4, D1, 0);                      // R6 mismatch
        wr(0, LD | RE | 8);
        respond(1, 4, D1, 1);                      // R6 error
        wr(0, LD | 3);
        respond(0, 0, D1, 0);                      // R6 no response wanted
        wr(0, LD | CK | 4);                        // R3 clock change
        tick(); tick();
        wr(0, LD | RE | 5);                        // R9 writes while busy
        wr(0, LD | 6);
        wr(1, 32'h0000_1234);
        respond(0, 4, D2, 1);
        wr(0, LD | AS | DT | RE | 18);             // R7 stop after data moves
        respond(0, 4, D1, 0);
        mv(4); mv(4);
        respond(0, 4, D2, 1);
        wr(2, 4);                                  // R7 R8 same-cycle collision
        wr(0, LD | AS | RE | 25);
        tick();
        mv_valid_i = 1; mv_bytes_i = 4;
        rsp_valid_i = 1; rsp_len_i = 4; rsp_data_i = D2;
        tick();
        mv_valid_i = 0; rsp_valid_i = 0;
        respond(0, 5, D1, 1);
        wr(2, 3);                                  // R8 saturation
        mv(10);
        respond(0, 4, D1, 0);
        reg_wr_en = 1; reg_wr_sel = 2; reg_wr_data = 20;
        mv_valid_i = 1; mv_bytes_i = 5;            // R8 load beats move
        tick();
        reg_wr_en = 0; mv_valid_i = 0;
        mv(7);
        wr(2, 0);
        wr(0, LD | CK | AS | RE | 7);              // R3 R7 clock change then stop
        respond(0, 4, D2, 1);
        wr(0, RE | 1);                             // stored, no start
        mv(2);                                     // R8 move at zero
        tick(); tick();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule